// File: doc/BRIEF.md
# Pointer-Indexed Console Port

This block is a two-register console port on a simple register bus. One register takes commands and answers status reads. The other moves bytes: writes go out on a transmit stream and reads pop bytes from a small receive buffer. Any value written to the command register is also kept as a read pointer. When that pointer is 3, the next status read returns an interrupt-cause byte instead of the normal status byte, and the read sets the pointer back to 0.

The port has one interrupt line, built from two sticky status flags. The TX flag is set when a byte is transmitted and cleared by a dedicated acknowledge command. The RX flag is set whenever a receive byte is accepted and cleared once a data read leaves the buffer empty. A single-cycle error pulse marks misuse: an acknowledge with nothing pending, a data read from an empty buffer, or a cause read with no cause pending.

Top module: `cons_ptr_port`

## Requirements
- R1: Every command write (`sel_i`=0, `we_i`=1) stores `wdata_i` as the read pointer. Apart from 0x28, a command value changes neither status flag, `irq_o` nor `err_o`.
- R2: Command 0x28 clears the TX flag. If the TX flag was already clear, `err_o` pulses for one cycle.
- R3: A status read (`sel_i`=0, `we_i`=0) while the pointer equals 3 returns 0x10 if TX is pending, else 0x20 if RX is pending, else 0x00 with an `err_o` pulse. The read resets the pointer to 0.
- R4: A status read with any other pointer value returns 0x04, with bit 0 set when RX is pending.
- R5: A data write (`sel_i`=1, `we_i`=1) emits `wdata_i` on `tx_data_o` with `tx_valid_o` high for one cycle, sets the TX flag and raises `irq_o`.
- R6: A data read (`sel_i`=1, `we_i`=0) returns the oldest buffered byte and removes it. The RX flag clears when the buffer becomes empty. A read of an empty buffer returns 0x00 and pulses `err_o`.
- R7: A receive byte accepted (`rx_valid_i` && `rx_ready_o`) always sets the RX flag and raises `irq_o`; there is no enable.
- R8: `irq_o` is the OR of the TX and RX flags. After reset the pointer, both flags and all outputs are 0, and `rx_ready_o` is 1.
- R9: Read data appears on `rdata_o` with `rvalid_o` high in the cycle after the request. The buffer holds DEPTH bytes. `rx_ready_o` is low when the buffer is full, and bytes offered then are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| sel_i | input | 1 | 0 = command/status register, 1 = data register |
| wdata_i | input | 8 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 8 | Read data |
| rx_valid_i | input | 1 | Receive byte offered |
| rx_data_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | Receive buffer can accept a byte |
| tx_valid_o | output | 1 | Transmit byte valid (one cycle) |
| tx_data_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Interrupt (TX or RX pending) |
| err_o | output | 1 | One-cycle pulse on illegal access |

## Verification
Every result is registered and is due exactly one clock edge after the request or receive byte that causes it. This covers read data, transmit pulses, flag changes seen on `irq_o`, and error pulses. The bench drives each stimulus for one cycle starting at a falling edge and samples at the following falling edge, which is the middle of the cycle in which the result is valid. Expected read bytes go into a queue before the request is issued. A monitor pops and compares them whenever `rvalid_o` is high, so a read that returns late, early or never shows up as a mismatch.

// File: rtl/cons_ptr_pkg.sv
package cons_ptr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_TX_ACK = 8'h28;
  localparam logic [BYTE_W-1:0] PTR_CAUSE  = 8'h03;
  localparam logic [BYTE_W-1:0] CAUSE_TX   = 8'h10;
  localparam logic [BYTE_W-1:0] CAUSE_RX   = 8'h20;
  localparam logic [BYTE_W-1:0] STAT_BASE  = 8'h04;
  typedef enum logic {SEL_CMD = 1'b0, SEL_DATA = 1'b1} reg_sel_e;
endpackage

// File: rtl/cons_rx_fifo.sv
module cons_rx_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         last_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign last_o  = (cnt_q == CW'(1));
  assign head_o  = mem[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o) else $error("push into full buffer"); // R9
endmodule

// File: rtl/cons_ptr_ctrl.sv
module cons_ptr_ctrl
  import cons_ptr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rx_push_i,
  input  logic              empty_i,
  input  logic              last_i,
  input  logic [BYTE_W-1:0] head_i,
  output logic              pop_o,
  output logic              rvalid_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              irq_o,
  output logic              err_o
);
  logic [BYTE_W-1:0] ptr_q, rd_mux;
  logic tx_st_q, rx_st_q;
  logic cmd_wr, cmd_rd, dat_wr, dat_rd, cause_rd, ack_wr, bad;

  assign cmd_wr   = req_i &&  we_i && (sel_i == SEL_CMD);
  assign cmd_rd   = req_i && !we_i && (sel_i == SEL_CMD);
  assign dat_wr   = req_i &&  we_i && (sel_i == SEL_DATA);
  assign dat_rd   = req_i && !we_i && (sel_i == SEL_DATA);
  assign cause_rd = cmd_rd && (ptr_q == PTR_CAUSE);
  assign ack_wr   = cmd_wr && (wdata_i == CMD_TX_ACK);
  assign pop_o    = dat_rd && !empty_i;
  assign irq_o    = tx_st_q || rx_st_q;

  always_comb begin
    if (sel_i == SEL_DATA)  rd_mux = empty_i ? '0 : head_i;
    else if (ptr_q == PTR_CAUSE)
      rd_mux = tx_st_q ? CAUSE_TX : (rx_st_q ? CAUSE_RX : '0);
    else                    rd_mux = STAT_BASE | {{(BYTE_W-1){1'b0}}, rx_st_q};
  end

  // misuse: ack with nothing pending, empty pop, cause read with no cause
  assign bad = (ack_wr && !tx_st_q) || (dat_rd && empty_i) ||
               (cause_rd && !tx_st_q && !rx_st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      tx_st_q    <= 1'b0;
      rx_st_q    <= 1'b0;
      rvalid_o   <= 1'b0;
      rdata_o    <= '0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
      err_o      <= 1'b0;
    end else begin
      if (cmd_wr)        ptr_q <= wdata_i;
      else if (cause_rd) ptr_q <= '0;
      if (dat_wr)        tx_st_q <= 1'b1;
      else if (ack_wr)   tx_st_q <= 1'b0;
      if (rx_push_i)                        rx_st_q <= 1'b1;
      else if (dat_rd && (empty_i || last_i)) rx_st_q <= 1'b0;
      rvalid_o   <= req_i && !we_i;
      if (req_i && !we_i) rdata_o <= rd_mux;
      tx_valid_o <= dat_wr;
      if (dat_wr) tx_data_o <= wdata_i;
      err_o      <= bad;
    end
  end

  AST_PTR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr |=> ptr_q == $past(wdata_i)) else $error("ptr load"); // R1
  AST_ACK_CLEARS_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_wr |=> !tx_st_q) else $error("ack"); // R2
  AST_CAUSE_CONSUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_rd |=> (ptr_q == '0) && rvalid_o) else $error("cause ptr"); // R3
  AST_TX_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_wr |=> tx_valid_o && irq_o) else $error("tx"); // R5
  AST_EMPTY_READ_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_rd && empty_i) |=> err_o && (rdata_o == '0)) else $error("empty rd"); // R6
  AST_RX_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i |=> irq_o) else $error("rx"); // R7
endmodule

// File: rtl/cons_ptr_port.sv
module cons_ptr_port
  import cons_ptr_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              rvalid_o,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              irq_o,
  output logic              err_o
);
  logic rx_push, pop, empty, full, last;
  logic [BYTE_W-1:0] head;

  assign rx_ready_o = !full;
  assign rx_push    = rx_valid_i && rx_ready_o;

  cons_rx_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .push_i(rx_push), .data_i(rx_data_i), .pop_i(pop),
    .head_o(head), .empty_o(empty), .full_o(full), .last_o(last)
  );

  cons_ptr_ctrl u_ctrl (
    .clk_i, .rst_ni, .req_i, .we_i, .sel_i, .wdata_i,
    .rx_push_i(rx_push), .empty_i(empty), .last_i(last), .head_i(head),
    .pop_o(pop), .rvalid_o, .rdata_o, .tx_valid_o, .tx_data_o, .irq_o, .err_o
  );

  AST_FULL_BLOCKS_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && rx_valid_i && !pop) |=> !rx_ready_o) else $error("full"); // R9
endmodule

// File: tb/cons_ptr_port_tb.sv
`timescale 1ns/1ps
module cons_ptr_port_tb;
  localparam int DEPTH = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, sel = 0, rx_valid = 0;
  logic [7:0] wdata = 0, rx_data = 0;
  logic rvalid, rx_ready, tx_valid, irq, err;
  logic [7:0] rdata, tx_data;
  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  cons_ptr_port #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .sel_i(sel),
    .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_ready_o(rx_ready), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .irq_o(irq), .err_o(err));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compare each returned read against the scoreboard
  always @(negedge clk) if (rst_n && rvalid) begin
    if (exp_q.size() == 0) chk("R9 unexpected rvalid", 8'd1, 8'd0);
    else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic acc(input logic s, input logic w, input logic [7:0] d);
    @(negedge clk); req = 1; sel = s; we = w; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask
  task automatic rd(input logic s, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    acc(s, 1'b0, 8'h00);
  endtask
  task automatic push(input logic [7:0] d);
    @(negedge clk); rx_valid = 1; rx_data = d;
    @(negedge clk); rx_valid = 0;
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 reset irq", {7'd0, irq}, 8'd0);
    chk("R8 reset err", {7'd0, err}, 8'd0);
    chk("R8 reset rvalid", {7'd0, rvalid}, 8'd0);
    chk("R8 reset tx_valid", {7'd0, tx_valid}, 8'd0);
    chk("R8 reset rx_ready", {7'd0, rx_ready}, 8'd1);

    rd(0, 8'h04, "R4 idle status");
    acc(0, 1, 8'h03);
    rd(0, 8'h00, "R3 spurious cause");
    chk("R3 spurious err", {7'd0, err}, 8'd1);
    rd(0, 8'h04, "R3 pointer consumed");

    acc(1, 1, 8'h41);
    chk("R5 tx_valid", {7'd0, tx_valid}, 8'd1);
    chk("R5 tx_data", tx_data, 8'h41);
    chk("R5 irq", {7'd0, irq}, 8'd1);

    acc(0, 1, 8'h12);
    chk("R1 other code keeps irq", {7'd0, irq}, 8'd1);
    chk("R1 other code no err", {7'd0, err}, 8'd0);
    rd(0, 8'h04, "R1 pointer 0x12 gives status");
    acc(0, 1, 8'h03);
    rd(0, 8'h10, "R3 tx cause");

    acc(0, 1, 8'h28);
    chk("R2 ack clears irq", {7'd0, irq}, 8'd0);
    chk("R2 ack no err", {7'd0, err}, 8'd0);
    acc(0, 1, 8'h28);
    chk("R2 ack unpending err", {7'd0, err}, 8'd1);

    push(8'h55);
    chk("R7 rx irq", {7'd0, irq}, 8'd1);
    push(8'h66);
    rd(0, 8'h05, "R4 status rx bit");
    acc(0, 1, 8'h03);
    rd(0, 8'h20, "R3 rx cause");
    rd(1, 8'h55, "R6 first byte");
    chk("R6 irq held while data", {7'd0, irq}, 8'd1);
    rd(1, 8'h66, "R6 second byte");
    chk("R6 irq drops when empty", {7'd0, irq}, 8'd0);
    chk("R6 no err on valid pop", {7'd0, err}, 8'd0);
    rd(1, 8'h00, "R6 empty read data");
    chk("R6 empty read err", {7'd0, err}, 8'd1);

    push(8'h77);
    acc(1, 1, 8'h42);
    acc(0, 1, 8'h03);
    rd(0, 8'h10, "R3 tx over rx priority");
    acc(0, 1, 8'h28);
    chk("R8 irq held by rx", {7'd0, irq}, 8'd1);
    rd(1, 8'h77, "R6 byte after ack");
    chk("R8 irq clear", {7'd0, irq}, 8'd0);

    for (int i = 0; i < DEPTH; i++) push(8'hA0 + 8'(i));
    chk("R9 full ready low", {7'd0, rx_ready}, 8'd0);
    push(8'hEE);
    for (int i = 0; i < DEPTH; i++) rd(1, 8'hA0 + 8'(i), "R9 buffered order");
    chk("R9 ready after drain", {7'd0, rx_ready}, 8'd1);
    rd(1, 8'h00, "R9 dropped byte absent");
    chk("R6 drained irq", {7'd0, irq}, 8'd0);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk("R9 missing read", 8'(exp_q.size()), 8'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule